// File: doc/BRIEF.md
# Instruction-Fetch Cache with Byte-Write Invalidation

This block is a set-associative instruction cache for a processor whose physical address space is 28 bits wide. Every byte address is an entry key of its own. The entry holds the three instruction bytes that start at that address, so a hit supplies a whole instruction in the same cycle the fetch address is presented. This lets the core issue one instruction per clock while it runs from cache.

The cache has three ports. The lookup port takes a translated fetch address and combinationally returns a hit flag and three bytes. The fill port writes three bytes after a miss. The first invalid way is used, or the way that already holds the address, or otherwise a victim picked by a free-running LFSR. The store-snoop port sees every byte the CPU writes. That byte can sit in the entries keyed at the written address and at the two addresses below it, so all ways at those three index positions are cleared in a single cycle.

The 1K index positions are split across four banks of 256 sets by the two low address bits. This guarantees that the three affected positions always land in different banks. A strobe marks any write that may change the address map, and the lookup in the cycle after such a write is forced to miss.

Top module: `icf_cache`

## Requirements
- R1: After reset every valid bit is clear, so every lookup misses until a fill has written the entry.
- R2: With `lk_req` high, a lookup of a filled address raises `lk_hit` in the same cycle. `lk_bytes[7:0]` carries the byte at the address, `[15:8]` the byte at address+1 and `[23:16]` the byte at address+2. With `lk_req` low, `lk_hit` stays low.
- R3: The tag is address bits 27:10. A lookup with the same bits 9:0 but a different tag misses.
- R4: Each byte address is a separate entry: index = address bits 9:0, bank = bits 1:0, set within the bank = bits 9:2. Neighbouring addresses hold independent data.
- R5: A fill of an address that is already cached overwrites that same way. A later lookup returns the new bytes.
- R6: A snooped write at address A invalidates the entries at index positions A, A-1 and A-2. Entries at A+1 and A-3 stay valid.
- R7: Invalidation clears all four ways at each affected index position, whatever their tags.
- R8: The index positions affected by a snoop wrap modulo 1024. A write at index 0 clears positions 0, 1023 and 1022, and position 1021 stays valid.
- R9: In the cycle directly after `map_wr` is high, every lookup misses. From the cycle after that on, lookups behave normally again.
- R10: When a snoop and a fill hit the same entry in the same cycle, the invalidation wins and the entry stays invalid.
- R11: A fill uses an invalid way first. When all four ways are valid, it replaces the way named by the two low bits of an 8-bit maximal-length LFSR that steps every clock and never reaches zero. After five fills of different tags to one index, exactly four of them hit, including the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 28 | Translated fetch address |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_bytes | output | 24 | Three instruction bytes, lowest address in bits 7:0 |
| fill_en | input | 1 | Fill write enable |
| fill_addr | input | 28 | Address of the fill |
| fill_bytes | input | 24 | Three bytes to store, lowest address in bits 7:0 |
| snp_en | input | 1 | A CPU byte write occurs |
| snp_addr | input | 28 | Address of the written byte |
| map_wr | input | 1 | Current write may change the address map |

## Verification
The bench builds the cache with its default parameters: 28-bit addresses, 10 index bits over four banks, four ways, three-byte entries and an 8-bit LFSR. These are the values at which every snoop splits across three distinct banks and the index wrap at position 0 occurs within the address range the bench drives. With four ways, a fifth distinct tag at one index forces a replacement driven by the LFSR. The bench checks that replacement through the count of surviving entries, so it does not depend on which way was chosen.

// File: rtl/icf_pkg.sv
package icf_pkg;

   // Galois feedback mask for a maximal-length LFSR of the given width.
   // Zero means the width has no entry and is rejected at elaboration.
   function automatic logic [31:0] lfsr_mask(input int width);
      case (width)
         4:       return 32'h0000_000C;
         8:       return 32'h0000_00B8;
         12:      return 32'h0000_0E08;
         16:      return 32'h0000_B400;
         default: return 32'h0000_0000;
      endcase
   endfunction

   // Number of bytes in an entry that contribute to one snooped write.
   function automatic int snoop_span(input int line_bytes);
      return line_bytes;
   endfunction

endpackage

// File: rtl/icf_lfsr.sv
module icf_lfsr #(
   parameter int          W    = 8,
   parameter logic [31:0] SEED = 32'h1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);
   import icf_pkg::*;

   localparam logic [31:0] MASK32 = lfsr_mask(W);
   localparam logic [W-1:0] MASK  = MASK32[W-1:0];
   localparam logic [W-1:0] INIT  = SEED[W-1:0];

   generate
      if (MASK32 == 32'h0) begin : g_bad_width
         $error("icf_lfsr: width %0d has no feedback mask", W);
      end
      if (INIT == '0) begin : g_bad_seed
         $error("icf_lfsr: seed must be non-zero");
      end
   endgenerate

   logic [W-1:0] st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= INIT;
      end else if (st_q[0]) begin
         st_q <= (st_q >> 1) ^ MASK;
      end else begin
         st_q <= st_q >> 1;
      end
   end

   assign state = st_q;

   // R11
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != '0)
      else $error("lfsr reached the all-zero state");

endmodule

// File: rtl/icf_snoop_dec.sv
module icf_snoop_dec #(
   parameter int IDX_W      = 10,
   parameter int BANK_W     = 2,
   parameter int LINE_BYTES = 3
) (
   input  logic                                      snp_en,
   input  logic [IDX_W-1:0]                          snp_idx,
   output logic [(1<<BANK_W)-1:0]                    inv_en,
   output logic [(1<<BANK_W)-1:0][IDX_W-BANK_W-1:0]  inv_set
);
   import icf_pkg::*;

   localparam int BANKS = 1 << BANK_W;
   localparam int SET_W = IDX_W - BANK_W;
   localparam int SPAN  = snoop_span(LINE_BYTES);

   generate
      if (SPAN > BANKS) begin : g_bad_span
         $error("icf_snoop_dec: %0d affected entries need as many banks", SPAN);
      end
   endgenerate

   // For each bank, find which of the byte offsets 0..SPAN-1 below the
   // written address falls into it. At most one can, as SPAN <= BANKS.
   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      always_comb begin
         logic [IDX_W-1:0] cand;
         inv_en[b]  = 1'b0;
         inv_set[b] = '0;
         for (int d = 0; d < SPAN; d++) begin
            cand = snp_idx - IDX_W'(d);
            if (cand[BANK_W-1:0] == BANK_W'(b)) begin
               inv_en[b]  = snp_en;
               inv_set[b] = cand[IDX_W-1:BANK_W];
            end
         end
      end
   end

endmodule

// File: rtl/icf_bank.sv
module icf_bank #(
   parameter int SET_W  = 8,
   parameter int WAYS   = 4,
   parameter int TAG_W  = 18,
   parameter int DATA_W = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SET_W-1:0]         lk_set,
   input  logic [TAG_W-1:0]         lk_tag,
   output logic                     lk_hit,
   output logic [DATA_W-1:0]        lk_data,
   input  logic                     fill_en,
   input  logic [SET_W-1:0]         fill_set,
   input  logic [TAG_W-1:0]         fill_tag,
   input  logic [DATA_W-1:0]        fill_data,
   input  logic [$clog2(WAYS)-1:0]  rnd_way,
   input  logic                     inv_en,
   input  logic [SET_W-1:0]         inv_set
);
   localparam int SETS  = 1 << SET_W;
   localparam int WAY_W = $clog2(WAYS);

   generate
      if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("icf_bank: way count %0d must be a power of two >= 2", WAYS);
      end
   endgenerate

   logic [TAG_W-1:0]  tag_q [SETS][WAYS];
   logic [DATA_W-1:0] dat_q [SETS][WAYS];
   logic [WAYS-1:0]   vld_q [SETS];

   logic [WAYS-1:0]   lk_match;
   logic [WAYS-1:0]   fill_match;
   logic [WAY_W-1:0]  fill_way;

   // Per-way tag comparison for lookup and for fill.
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign lk_match[w]   = vld_q[lk_set][w]   && (tag_q[lk_set][w]   == lk_tag);
      assign fill_match[w] = vld_q[fill_set][w] && (tag_q[fill_set][w] == fill_tag);
   end

   assign lk_hit = |lk_match;

   always_comb begin
      lk_data = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (lk_match[w]) lk_data = lk_data | dat_q[lk_set][w];
      end
   end

   // Way choice: the way already holding the tag, else the lowest invalid
   // way, else the pseudo-random victim.
   always_comb begin
      logic found;
      found    = 1'b0;
      fill_way = rnd_way;
      for (int w = 0; w < WAYS; w++) begin
         if (!found && fill_match[w]) begin
            fill_way = WAY_W'(w);
            found    = 1'b1;
         end
      end
      for (int w = 0; w < WAYS; w++) begin
         if (!found && !vld_q[fill_set][w]) begin
            fill_way = WAY_W'(w);
            found    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[fill_set][fill_way] <= fill_tag;
         dat_q[fill_set][fill_way] <= fill_data;
      end
   end

   // Invalidation is applied after the fill so that it wins on a collision.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else begin
         if (fill_en) vld_q[fill_set][fill_way] <= 1'b1;
         if (inv_en)  vld_q[inv_set] <= '0;
      end
   end

   // R5
   single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match))
      else $error("address held in more than one way");

   // R7
   inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en |=> (vld_q[$past(inv_set)] == '0))
      else $error("ways left valid after invalidation");

   // R10
   fill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !(inv_en && inv_set == fill_set))
      |=> vld_q[$past(fill_set)][$past(fill_way)])
      else $error("filled way not valid");

   // R10
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && inv_en && inv_set == fill_set)
      |=> !vld_q[$past(fill_set)][$past(fill_way)])
      else $error("fill overrode a same-cycle invalidation");

endmodule

// File: rtl/icf_cache.sv
module icf_cache #(
   parameter int          ADDR_W     = 28,
   parameter int          IDX_W      = 10,
   parameter int          BANK_W     = 2,
   parameter int          WAYS       = 4,
   parameter int          LINE_BYTES = 3,
   parameter int          LFSR_W     = 8,
   parameter logic [31:0] LFSR_SEED  = 32'h5B
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lk_req,
   input  logic [ADDR_W-1:0]        lk_addr,
   output logic                     lk_hit,
   output logic [8*LINE_BYTES-1:0]  lk_bytes,
   input  logic                     fill_en,
   input  logic [ADDR_W-1:0]        fill_addr,
   input  logic [8*LINE_BYTES-1:0]  fill_bytes,
   input  logic                     snp_en,
   input  logic [ADDR_W-1:0]        snp_addr,
   input  logic                     map_wr
);
   localparam int BANKS  = 1 << BANK_W;
   localparam int SET_W  = IDX_W - BANK_W;
   localparam int TAG_W  = ADDR_W - IDX_W;
   localparam int DATA_W = 8 * LINE_BYTES;
   localparam int WAY_W  = $clog2(WAYS);

   generate
      if (IDX_W <= BANK_W) begin : g_bad_idx
         $error("icf_cache: index width must exceed bank select width");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("icf_cache: address must be wider than the index");
      end
      if (LFSR_W < WAY_W) begin : g_bad_lfsr
         $error("icf_cache: LFSR narrower than the way number");
      end
   endgenerate

   logic [LFSR_W-1:0]                 rnd;
   logic                              blk_q;
   logic [BANKS-1:0]                  inv_en;
   logic [BANKS-1:0][SET_W-1:0]       inv_set;
   logic [BANKS-1:0]                  bank_hit;
   logic [BANKS-1:0][DATA_W-1:0]      bank_data;

   icf_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_rnd (
      .clk   (clk),
      .rst_n (rst_n),
      .state (rnd)
   );

   icf_snoop_dec #(.IDX_W(IDX_W), .BANK_W(BANK_W), .LINE_BYTES(LINE_BYTES)) u_snp (
      .snp_en  (snp_en),
      .snp_idx (snp_addr[IDX_W-1:0]),
      .inv_en  (inv_en),
      .inv_set (inv_set)
   );

   // A map-changing write blocks lookup in the following cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) blk_q <= 1'b0;
      else        blk_q <= map_wr;
   end

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic bank_fill;
      assign bank_fill = fill_en && (fill_addr[BANK_W-1:0] == BANK_W'(b));

      icf_bank #(.SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .lk_set    (lk_addr[IDX_W-1:BANK_W]),
         .lk_tag    (lk_addr[ADDR_W-1:IDX_W]),
         .lk_hit    (bank_hit[b]),
         .lk_data   (bank_data[b]),
         .fill_en   (bank_fill),
         .fill_set  (fill_addr[IDX_W-1:BANK_W]),
         .fill_tag  (fill_addr[ADDR_W-1:IDX_W]),
         .fill_data (fill_bytes),
         .rnd_way   (rnd[WAY_W-1:0]),
         .inv_en    (inv_en[b]),
         .inv_set   (inv_set[b])
      );
   end

   assign lk_hit   = lk_req && !blk_q && bank_hit[lk_addr[BANK_W-1:0]];
   assign lk_bytes = bank_data[lk_addr[BANK_W-1:0]];

   // R9
   map_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      map_wr |=> !lk_hit)
      else $error("lookup hit right after a map-changing write");

   // R6
   snoop_spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_en |-> ($countones(inv_en) == LINE_BYTES))
      else $error("snoop did not reach the expected number of banks");

   // R2
   hit_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |-> !lk_hit)
      else $error("hit without a lookup request");

endmodule

// File: tb/icf_cache_tb.sv
module icf_cache_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [27:0] lk_addr = '0;
   logic        lk_hit;
   logic [23:0] lk_bytes;
   logic        fill_en = 1'b0;
   logic [27:0] fill_addr = '0;
   logic [23:0] fill_bytes = '0;
   logic        snp_en = 1'b0;
   logic [27:0] snp_addr = '0;
   logic        map_wr = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   icf_cache u_dut (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
      .lk_hit(lk_hit), .lk_bytes(lk_bytes), .fill_en(fill_en),
      .fill_addr(fill_addr), .fill_bytes(fill_bytes), .snp_en(snp_en),
      .snp_addr(snp_addr), .map_wr(map_wr)
   );

   function automatic logic [27:0] mk(input logic [17:0] tag, input logic [9:0] idx);
      return {tag, idx};
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_fill(input logic [27:0] a, input logic [23:0] d);
      fill_en = 1'b1; fill_addr = a; fill_bytes = d;
      step();
      fill_en = 1'b0;
   endtask

   task automatic do_snoop(input logic [27:0] a);
      snp_en = 1'b1; snp_addr = a;
      step();
      snp_en = 1'b0;
   endtask

   task automatic probe(input string req, input logic [27:0] a, input logic exp_hit,
                        input logic [23:0] exp_d);
      lk_req = 1'b1; lk_addr = a;
      #1;
      checks++;
      if (lk_hit !== exp_hit || (exp_hit && lk_bytes !== exp_d)) begin
         errors++;
         $display("FAIL %s addr=%h hit=%b bytes=%h expected hit=%b bytes=%h",
                  req, a, lk_hit, lk_bytes, exp_hit, exp_d);
      end
      lk_req = 1'b0;
   endtask

   task automatic t_reset();
      probe("R1", mk(18'h0, 10'h000), 1'b0, 24'h0);
      probe("R1", mk(18'h3FFFF, 10'h3FF), 1'b0, 24'h0);
   endtask

   task automatic t_basic();
      do_fill(mk(18'h00AB, 10'h040), 24'h33_22_11);
      do_fill(mk(18'h00AB, 10'h041), 24'h66_55_44);
      probe("R2", mk(18'h00AB, 10'h040), 1'b1, 24'h33_22_11);
      probe("R4", mk(18'h00AB, 10'h041), 1'b1, 24'h66_55_44);
      probe("R3", mk(18'h00AC, 10'h040), 1'b0, 24'h0);
      // R2: no request, no hit
      lk_req = 1'b0; lk_addr = mk(18'h00AB, 10'h040);
      #1; checks++;
      if (lk_hit !== 1'b0) begin
         errors++;
         $display("FAIL R2 hit without request: hit=%b expected 0", lk_hit);
      end
   endtask

   task automatic t_refill();
      do_fill(mk(18'h0777, 10'h080), 24'hAA_AA_AA);
      do_fill(mk(18'h0777, 10'h080), 24'hBB_BB_BB);
      probe("R5", mk(18'h0777, 10'h080), 1'b1, 24'hBB_BB_BB);
   endtask

   task automatic t_snoop();
      for (int k = -3; k <= 1; k++) begin
         logic [9:0] ix;
         ix = 10'(10'h200 + k);
         do_fill(mk(18'h0123, ix), {14'h0, ix});
      end
      do_snoop(mk(18'h0123, 10'h200));
      probe("R6", mk(18'h0123, 10'h200), 1'b0, 24'h0);
      probe("R6", mk(18'h0123, 10'h1FF), 1'b0, 24'h0);
      probe("R6", mk(18'h0123, 10'h1FE), 1'b0, 24'h0);
      probe("R6", mk(18'h0123, 10'h1FD), 1'b1, 24'h0001FD);
      probe("R6", mk(18'h0123, 10'h201), 1'b1, 24'h000201);
   endtask

   task automatic t_all_ways();
      do_fill(mk(18'h0011, 10'h0C0), 24'h11_11_11);
      do_fill(mk(18'h0022, 10'h0C0), 24'h22_22_22);
      probe("R7", mk(18'h0022, 10'h0C0), 1'b1, 24'h22_22_22);
      do_snoop(mk(18'h0333, 10'h0C0));
      probe("R7", mk(18'h0011, 10'h0C0), 1'b0, 24'h0);
      probe("R7", mk(18'h0022, 10'h0C0), 1'b0, 24'h0);
   endtask

   task automatic t_wrap();
      do_fill(mk(18'h0005, 10'h3FF), 24'h0A_0A_0A);
      do_fill(mk(18'h0009, 10'h3FE), 24'h0B_0B_0B);
      do_fill(mk(18'h0005, 10'h3FD), 24'h0C_0C_0C);
      do_fill(mk(18'h0006, 10'h000), 24'h0D_0D_0D);
      do_snoop(mk(18'h0006, 10'h000));
      probe("R8", mk(18'h0006, 10'h000), 1'b0, 24'h0);
      probe("R8", mk(18'h0005, 10'h3FF), 1'b0, 24'h0);
      probe("R8", mk(18'h0009, 10'h3FE), 1'b0, 24'h0);
      probe("R8", mk(18'h0005, 10'h3FD), 1'b1, 24'h0C_0C_0C);
   endtask

   task automatic t_map();
      do_fill(mk(18'h0444, 10'h100), 24'hC0_FF_EE);
      probe("R9", mk(18'h0444, 10'h100), 1'b1, 24'hC0_FF_EE);
      map_wr = 1'b1;
      step();
      map_wr = 1'b0;
      probe("R9", mk(18'h0444, 10'h100), 1'b0, 24'h0);
      step();
      probe("R9", mk(18'h0444, 10'h100), 1'b1, 24'hC0_FF_EE);
   endtask

   task automatic t_collide();
      fill_en = 1'b1; fill_addr = mk(18'h0555, 10'h180); fill_bytes = 24'h12_34_56;
      snp_en  = 1'b1; snp_addr  = mk(18'h0555, 10'h181);
      step();
      fill_en = 1'b0; snp_en = 1'b0;
      probe("R10", mk(18'h0555, 10'h180), 1'b0, 24'h0);
   endtask

   task automatic t_replace();
      int hits;
      hits = 0;
      for (int k = 0; k < 5; k++) do_fill(mk(18'(18'h1000 + k), 10'h155), 24'(k + 1));
      for (int k = 0; k < 5; k++) begin
         lk_req = 1'b1; lk_addr = mk(18'(18'h1000 + k), 10'h155);
         #1;
         if (lk_hit) hits++;
         lk_req = 1'b0;
      end
      checks++;
      if (hits != 4) begin
         errors++;
         $display("FAIL R11 hits after five fills=%0d expected 4", hits);
      end
      probe("R11", mk(18'h1004, 10'h155), 1'b1, 24'h000005);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired: done=0 expected 1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_refill();
      t_snoop();
      t_all_ways();
      t_wrap();
      t_map();
      t_collide();
      t_replace();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule